// File: doc/BRIEF.md
# Cascadable Down-Counter Timer Pair

This block holds two hardware timers: a narrow low timer and a wide high timer. Each timer has a setting register, a counter that software can read, and a control word. On its own, each timer counts down on an external tick-enable from its setting value to zero. It then reloads and flags a terminal count. The status bit for a terminal count is sticky. An interrupt pulse is sent only when the timer's interrupt enable is set.

The control word of the low timer has a combine bit. When that bit is set, the high timer no longer uses the tick. Instead it takes one step each time the low timer finishes a period, so the low timer acts as a prescaler. The high timer's count is also presented inverted, so it reads as a rising count. With an 8 MHz tick and a low setting of 7, the low timer completes one period per microsecond. Software then reads elapsed microseconds directly. It presets the time by writing the complement of the start value into the high setting register and pulsing the reset bit. When the rising count passes its top it wraps to the complement of the setting and raises the high timer's interrupt.

Access is through a simple word-addressed read/write port. The word addresses are 0 low control, 1 low setting, 2 low count, 4 high control, 5 high setting, 6 high count, 7 interrupt status. In both control words, bit 0 is run, bit 1 is reset (write-only, reads 0) and bit 2 is interrupt enable. Bit 3 of the low control word is combine. The status word holds bit 0 for the low timer and bit 1 for the high timer.

Top module: `cascade_timer_pair`

## Requirements
- R1: After reset, every register (addresses 0,1,2,4,5,6,7) reads 0 and both interrupt outputs are low.
- R2: A running timer decrements on each clock with tick_i high. From zero it reloads its setting value, so a period lasts setting+1 ticks.
- R3: With control bit 0 (run) clear, a timer's count does not change under ticks.
- R4: Writing a control word with bit 1 set reloads that timer's count from its setting at that edge. If the same low-control write has bit 3 set, the high count reloads as well. Bit 1 reads back as 0.
- R5: Writing a setting register alone leaves the current count unchanged.
- R6: With bit 3 of the low control set, the high timer advances once per completed low period and ignores tick_i and its own run bit.
- R7: With combine set, address 6 reads the bitwise inverse of the high down-count. With a setting of 0xFFFFFFFF it reads 0 right after a reset.
- R8: In combine mode, when the rising high count passes 0xFFFFFFFF it restarts at the complement of the high setting, and status bit 1 is set.
- R9: A terminal count drives a one-cycle pulse on irq_low_o or irq_high_o only while that timer's control bit 2 is set. No pulse occurs while bit 2 is clear.
- R10: Status bits (bit 0 low, bit 1 high) at address 7 are set by terminal counts, stay set, and are cleared only by writing 1 to them.
- R11: rdata_o is loaded from the addressed register on the edge where rd_en_i is high, and holds that value until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Count enable, one pulse per timer tick |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 3 | Word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| irq_low_o | output | 1 | Low-timer terminal-count pulse |
| irq_high_o | output | 1 | High-timer terminal-count pulse |

## Verification
A control write with the reset bit reloads the counters at that same edge. Each ticked edge after that moves the counts by one step. The bench therefore drives tick_i for an exact number of edges, stops it, and only then reads. Read data appears one edge after rd_en_i and is sampled at the following falling edge. Interrupt pulses are registered, so they show in the cycle after the terminal-count edge. They are tallied at falling edges while ticks run and compared afterwards.

// File: rtl/ctp_pkg.sv
package ctp_pkg;
    localparam int unsigned ADDR_W = 3;

    localparam logic [ADDR_W-1:0] A_LOW_CTRL  = 3'd0;
    localparam logic [ADDR_W-1:0] A_LOW_SET   = 3'd1;
    localparam logic [ADDR_W-1:0] A_LOW_CNT   = 3'd2;
    localparam logic [ADDR_W-1:0] A_HIGH_CTRL = 3'd4;
    localparam logic [ADDR_W-1:0] A_HIGH_SET  = 3'd5;
    localparam logic [ADDR_W-1:0] A_HIGH_CNT  = 3'd6;
    localparam logic [ADDR_W-1:0] A_STATUS    = 3'd7;

    localparam int unsigned B_RUN  = 0;
    localparam int unsigned B_RST  = 1;
    localparam int unsigned B_IE   = 2;
    localparam int unsigned B_COMB = 3;

    typedef struct packed {
        logic comb;
        logic ie;
        logic run;
    } tmr_ctrl_t;
endpackage

// File: rtl/ctp_down_timer.sv
module ctp_down_timer #(
    parameter int unsigned W = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step_i,
    input  logic         reload_i,
    input  logic [W-1:0] setting_i,
    output logic [W-1:0] count_o,
    output logic         tc_o
);
    logic [W-1:0] cnt_d, cnt_q;
    logic         tc;

    always_comb begin
        cnt_d = cnt_q;
        tc    = 1'b0;
        if (reload_i) begin
            cnt_d = setting_i;
        end else if (step_i) begin
            if (cnt_q == '0) begin
                cnt_d = setting_i;
                tc    = 1'b1;
            end else begin
                cnt_d = cnt_q - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign count_o = cnt_q;
    assign tc_o    = tc;
endmodule

// File: rtl/ctp_regs.sv
module ctp_regs
    import ctp_pkg::*;
#(
    parameter int unsigned LOW_W  = 24,
    parameter int unsigned HIGH_W = 32,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic              rd_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [LOW_W-1:0]  low_cnt_i,
    input  logic [HIGH_W-1:0] high_cnt_i,
    input  logic              low_tc_i,
    input  logic              high_tc_i,
    output tmr_ctrl_t         low_ctrl_o,
    output tmr_ctrl_t         high_ctrl_o,
    output logic [LOW_W-1:0]  low_set_o,
    output logic [HIGH_W-1:0] high_set_o,
    output logic              low_reload_o,
    output logic              high_reload_o,
    output logic [1:0]        sts_o,
    output logic [DATA_W-1:0] rdata_o,
    output logic              irq_low_o,
    output logic              irq_high_o
);
    typedef struct packed {
        tmr_ctrl_t         lctl;
        tmr_ctrl_t         hctl;
        logic [LOW_W-1:0]  lset;
        logic [HIGH_W-1:0] hset;
        logic [1:0]        sts;
        logic [1:0]        irq;
        logic [DATA_W-1:0] rdata;
    } regs_t;

    regs_t r_d, r_q;
    logic  wr_lctl, wr_hctl, wr_sts;
    logic  low_rst, high_rst;
    logic [HIGH_W-1:0] high_view;

    assign wr_lctl  = wr_en_i && (addr_i == A_LOW_CTRL);
    assign wr_hctl  = wr_en_i && (addr_i == A_HIGH_CTRL);
    assign wr_sts   = wr_en_i && (addr_i == A_STATUS);
    assign low_rst  = wr_lctl && wdata_i[B_RST];
    assign high_rst = (wr_hctl && wdata_i[B_RST]) ||
                      (low_rst && wdata_i[B_COMB]);
    assign high_view = r_q.lctl.comb ? ~high_cnt_i : high_cnt_i;

    always_comb begin
        r_d = r_q;
        if (wr_lctl) begin
            r_d.lctl.run  = wdata_i[B_RUN];
            r_d.lctl.ie   = wdata_i[B_IE];
            r_d.lctl.comb = wdata_i[B_COMB];
        end
        if (wr_hctl) begin
            r_d.hctl.run  = wdata_i[B_RUN];
            r_d.hctl.ie   = wdata_i[B_IE];
            r_d.hctl.comb = 1'b0;
        end
        if (wr_en_i && addr_i == A_LOW_SET)  r_d.lset = wdata_i[LOW_W-1:0];
        if (wr_en_i && addr_i == A_HIGH_SET) r_d.hset = wdata_i[HIGH_W-1:0];
        r_d.sts = r_q.sts & ~(wr_sts ? wdata_i[1:0] : 2'b00);
        r_d.sts = r_d.sts | {high_tc_i, low_tc_i};
        r_d.irq = {high_tc_i & r_q.hctl.ie, low_tc_i & r_q.lctl.ie};
        if (rd_en_i) begin
            unique case (addr_i)
                A_LOW_CTRL:  r_d.rdata = DATA_W'({r_q.lctl.comb, r_q.lctl.ie, 1'b0, r_q.lctl.run});
                A_LOW_SET:   r_d.rdata = DATA_W'(r_q.lset);
                A_LOW_CNT:   r_d.rdata = DATA_W'(low_cnt_i);
                A_HIGH_CTRL: r_d.rdata = DATA_W'({r_q.hctl.ie, 1'b0, r_q.hctl.run});
                A_HIGH_SET:  r_d.rdata = DATA_W'(r_q.hset);
                A_HIGH_CNT:  r_d.rdata = DATA_W'(high_view);
                A_STATUS:    r_d.rdata = DATA_W'(r_q.sts);
                default:     r_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign low_ctrl_o    = r_q.lctl;
    assign high_ctrl_o   = r_q.hctl;
    assign low_set_o     = r_q.lset;
    assign high_set_o    = r_q.hset;
    assign low_reload_o  = low_rst;
    assign high_reload_o = high_rst;
    assign sts_o         = r_q.sts;
    assign rdata_o       = r_q.rdata;
    assign irq_low_o     = r_q.irq[0];
    assign irq_high_o    = r_q.irq[1];
endmodule

// File: rtl/cascade_timer_pair.sv
module cascade_timer_pair
    import ctp_pkg::*;
#(
    parameter int unsigned LOW_W  = 24,
    parameter int unsigned HIGH_W = 32,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              wr_en_i,
    input  logic              rd_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              irq_low_o,
    output logic              irq_high_o
);
    tmr_ctrl_t         low_ctrl, high_ctrl;
    logic [LOW_W-1:0]  low_set, low_cnt;
    logic [HIGH_W-1:0] high_set, high_cnt;
    logic              low_reload, high_reload;
    logic              low_step, high_step;
    logic              low_tc, high_tc;
    logic              combine;
    logic [1:0]        sts;

    assign combine   = low_ctrl.comb;
    assign low_step  = low_ctrl.run && tick_i;
    assign high_step = combine ? low_tc : (high_ctrl.run && tick_i);

    ctp_regs #(.LOW_W(LOW_W), .HIGH_W(HIGH_W), .DATA_W(DATA_W)) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en_i      (wr_en_i),
        .rd_en_i      (rd_en_i),
        .addr_i       (addr_i),
        .wdata_i      (wdata_i),
        .low_cnt_i    (low_cnt),
        .high_cnt_i   (high_cnt),
        .low_tc_i     (low_tc),
        .high_tc_i    (high_tc),
        .low_ctrl_o   (low_ctrl),
        .high_ctrl_o  (high_ctrl),
        .low_set_o    (low_set),
        .high_set_o   (high_set),
        .low_reload_o (low_reload),
        .high_reload_o(high_reload),
        .sts_o        (sts),
        .rdata_o      (rdata_o),
        .irq_low_o    (irq_low_o),
        .irq_high_o   (irq_high_o)
    );

    ctp_down_timer #(.W(LOW_W)) u_low (
        .clk      (clk),
        .rst_n    (rst_n),
        .step_i   (low_step),
        .reload_i (low_reload),
        .setting_i(low_set),
        .count_o  (low_cnt),
        .tc_o     (low_tc)
    );

    ctp_down_timer #(.W(HIGH_W)) u_high (
        .clk      (clk),
        .rst_n    (rst_n),
        .step_i   (high_step),
        .reload_i (high_reload),
        .setting_i(high_set),
        .count_o  (high_cnt),
        .tc_o     (high_tc)
    );
endmodule

// File: rtl/ctp_checker.sv
module ctp_checker
    import ctp_pkg::*;
#(
    parameter int unsigned LOW_W  = 24,
    parameter int unsigned HIGH_W = 32,
    parameter int unsigned DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en_i,
    input logic              rd_en_i,
    input logic [ADDR_W-1:0] addr_i,
    input logic [DATA_W-1:0] wdata_i,
    input logic [DATA_W-1:0] rdata_o,
    input logic              irq_low_o,
    input logic              irq_high_o,
    input logic [1:0]        sts,
    input logic [LOW_W-1:0]  low_cnt,
    input logic              low_step,
    input logic              low_reload,
    input logic              low_run,
    input logic [HIGH_W-1:0] high_cnt,
    input logic              high_reload,
    input logic              low_tc,
    input logic              combine
);
    // R2
    low_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (low_step && !low_reload && low_cnt != '0) |=> (low_cnt + 1'b1) == $past(low_cnt));

    // R3
    low_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!low_run && !low_reload) |=> $stable(low_cnt));

    // R6
    high_waits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (combine && !high_reload && !low_tc) |=> $stable(high_cnt));

    // R9
    irq_low_sts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_low_o |-> sts[0]);

    // R9
    irq_high_sts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_high_o |-> sts[1]);

    // R10
    sts_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sts[1] && !(wr_en_i && addr_i == A_STATUS && wdata_i[1])) |=> sts[1]);

    // R11
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en_i |=> $stable(rdata_o));
endmodule

bind cascade_timer_pair ctp_checker #(.LOW_W(LOW_W), .HIGH_W(HIGH_W), .DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en_i    (wr_en_i),
    .rd_en_i    (rd_en_i),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .rdata_o    (rdata_o),
    .irq_low_o  (irq_low_o),
    .irq_high_o (irq_high_o),
    .sts        (sts),
    .low_cnt    (low_cnt),
    .low_step   (low_step),
    .low_reload (low_reload),
    .low_run    (low_ctrl.run),
    .high_cnt   (high_cnt),
    .high_reload(high_reload),
    .low_tc     (low_tc),
    .combine    (combine)
);

// File: tb/tb_cascade_timer_pair.sv
module tb_cascade_timer_pair;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_i = 1'b0;
    logic        wr_en_i = 1'b0;
    logic        rd_en_i = 1'b0;
    logic [2:0]  addr_i = '0;
    logic [31:0] wdata_i = '0;
    logic [31:0] rdata_o;
    logic        irq_low_o, irq_high_o;

    int checks = 0;
    int errors = 0;
    int lo_pulses = 0;
    int hi_pulses = 0;

    always #10 clk = ~clk;

    cascade_timer_pair dut (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .wr_en_i(wr_en_i),
        .rd_en_i(rd_en_i), .addr_i(addr_i), .wdata_i(wdata_i),
        .rdata_o(rdata_o), .irq_low_o(irq_low_o), .irq_high_o(irq_high_o)
    );

    always @(negedge clk) begin
        if (irq_low_o)  lo_pulses++;
        if (irq_high_o) hi_pulses++;
    end

    typedef struct packed {
        logic [23:0] lset;
        logic [31:0] hset;
        logic        comb;
        logic [15:0] ticks;
        logic [23:0] exp_low;
        logic [31:0] exp_high;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{24'd7, 32'hFFFFFFFF, 1'b1, 16'd0,  24'd7, 32'h0},
        '{24'd7, 32'hFFFFFFFF, 1'b1, 16'd8,  24'd7, 32'h1},
        '{24'd7, 32'hFFFFFFFF, 1'b1, 16'd21, 24'd2, 32'h2},
        '{24'd3, 32'hFFFFFFFF, 1'b1, 16'd10, 24'd1, 32'h2},
        '{24'd7, 32'h5,        1'b1, 16'd16, 24'd7, 32'hFFFFFFFC},
        '{24'd9, 32'h1234,     1'b0, 16'd4,  24'd5, 32'h1234},
        '{24'd2, 32'h0,        1'b0, 16'd7,  24'd1, 32'h0}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en_i = 1'b1; addr_i = a; wdata_i = d;
        @(negedge clk);
        wr_en_i = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        rd_en_i = 1'b1; addr_i = a;
        @(negedge clk);
        rd_en_i = 1'b0;
        d = rdata_o;
    endtask

    task automatic ticks(input int n);
        @(negedge clk);
        tick_i = 1'b1;
        repeat (n) @(negedge clk);
        tick_i = 1'b0;
    endtask

    initial begin
        #3_000_000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        foreach (VECS[i]) begin end
        for (int a = 0; a < 8; a++) begin
            if (a != 3) begin
                rd(3'(a), v);
                check("R1 reset read", v, 32'h0);
            end
        end
        check("R1 irq low", {31'b0, irq_low_o}, 32'h0);
        check("R1 irq high", {31'b0, irq_high_o}, 32'h0);

        // R2 R6 R7 table walk
        for (int i = 0; i < NV; i++) begin
            wr(3'd1, {8'h0, VECS[i].lset});
            wr(3'd5, VECS[i].hset);
            wr(3'd4, 32'h2);
            wr(3'd0, VECS[i].comb ? 32'hB : 32'h3);
            if (VECS[i].ticks != 0) ticks(int'(VECS[i].ticks));
            rd(3'd2, v);
            check(VECS[i].comb ? "R6 low count" : "R2 low count", v, {8'h0, VECS[i].exp_low});
            rd(3'd6, v);
            check(VECS[i].comb ? "R7 high count" : "R3 high idle", v, VECS[i].exp_high);
        end

        // R3: stop freezes (low left at 1 from last vector)
        wr(3'd1, 32'd9);
        wr(3'd0, 32'h3);
        ticks(4);
        wr(3'd0, 32'h0);
        ticks(5);
        rd(3'd2, v);
        check("R3 stopped count", v, 32'd5);
        // R5: setting write alone
        wr(3'd1, 32'd20);
        rd(3'd2, v);
        check("R5 setting no effect", v, 32'd5);
        // R4: reset reloads, reset bit reads 0
        wr(3'd0, 32'h3);
        rd(3'd2, v);
        check("R4 reload", v, 32'd20);
        rd(3'd0, v);
        check("R4 ctrl readback", v, 32'h1);

        // R8 R9 R10: combine wrap
        wr(3'd7, 32'h3);
        wr(3'd5, 32'd2);
        wr(3'd4, 32'h4);
        wr(3'd1, 32'd0);
        wr(3'd0, 32'hB);
        rd(3'd6, v);
        check("R8 preset", v, 32'hFFFFFFFD);
        lo_pulses = 0; hi_pulses = 0;
        ticks(2);
        rd(3'd6, v);
        check("R8 top", v, 32'hFFFFFFFF);
        check("R9 no high pulse yet", 32'(hi_pulses), 32'd0);
        ticks(1);
        rd(3'd6, v);
        check("R8 wrap", v, 32'hFFFFFFFD);
        check("R9 one high pulse", 32'(hi_pulses), 32'd1);
        check("R9 low disabled", 32'(lo_pulses), 32'd0);
        rd(3'd7, v);
        check("R10 status", v, 32'h3);
        wr(3'd7, 32'h2);
        rd(3'd7, v);
        check("R10 w1c high", v, 32'h1);
        wr(3'd7, 32'h1);
        rd(3'd7, v);
        check("R10 w1c low", v, 32'h0);

        // R9: standalone high with enable
        wr(3'd0, 32'h0);
        wr(3'd5, 32'd3);
        wr(3'd4, 32'h7);
        hi_pulses = 0;
        ticks(4);
        rd(3'd6, v);
        check("R2 high reload", v, 32'd3);
        check("R9 standalone pulse", 32'(hi_pulses), 32'd1);
        // R11: hold
        repeat (4) @(negedge clk);
        check("R11 rdata hold", rdata_o, 32'd3);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule